// File: doc/BRIEF.md
# Stop-State Entry and Wake Controller

This block manages a processor's deepest low-power state. When the core decodes a stop instruction, it pulses `stop_req`. The block then enters the stopped state, or it treats the request as a no-op when the stop-disable flag is set. In the stopped state it drops both the core clock enable and the oscillator enable. The block itself runs on an always-on clock, so it keeps watching for wake-up while the core clock is off.

Three active-low lines can wake the part: the maskable interrupt, the non-maskable-style interrupt and the reset pin. A latched, pending edge-type maskable interrupt can also wake it. Every wake input passes through a two-flop synchronizer.

Once a wake is seen, the oscillator enable comes back first. The core clock enable returns only after a programmable settle count. A reset wake may skip that count when a configuration input allows it. When the core clock restarts, a one-cycle strobe reports a one-hot code that tells the core how to resume.

Top module: `stopctl_top`

## Requirements
- R1: After reset, `core_clk_en` and `osc_en` are 1, and `stop_active`, `stop_nop`, `wake_valid` and `wake_code` are 0.
- R2: A `stop_req` pulse with `stop_dis`=0, taken while running, makes `stop_active` 1 and both `core_clk_en` and `osc_en` 0 on the next clock edge.
- R3: A `stop_req` pulse with `stop_dis`=1 does not stop the part. The clock enables stay 1, and `stop_nop` is 1 for exactly the one cycle after the request.
- R4: A low level on `irq_n` wakes the part only when `i_mask`=0. The resume code is then bit 1 (service the maskable interrupt). With `i_mask`=1, the line has no effect and the part stays stopped.
- R5: `irq_pend`=1 together with `i_mask`=0 wakes the part with code bit 1, even when `irq_n` is high.
- R6: A low level on `xirq_n` wakes the part whatever the value of `x_mask`. With `x_mask`=0 the code is bit 2 (service the non-maskable interrupt). With `x_mask`=1 the code is bit 0 (continue with the next instruction).
- R7: A low level on `pin_rst_n` wakes the part with code bit 3 (full reset sequence).
- R8: When several wake sources are active together, the reset pin wins, then `xirq_n`, then the maskable source.
- R9: `osc_en` rises on the third clock edge after a wake input falls, counted from the first edge that samples it. `core_clk_en` rises `settle_cycles`+1 edges after `osc_en` does.
- R10: When `rst_bypass_en`=1, a reset-pin wake raises `core_clk_en` on the same edge as `osc_en`. Wakes from other sources still wait for the full settle count.
- R11: `wake_valid` is 1 for exactly one cycle, on the cycle in which `core_clk_en` returns to 1. `wake_code` is one-hot while `wake_valid` is 1 and zero at all other times.
- R12: A `stop_req` received while the part is stopped or settling is ignored: the wake timing and the resume code do not change, and the part stays running afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| stop_req | input | 1 | One-cycle pulse: the core decoded a stop instruction |
| stop_dis | input | 1 | Stop-disable flag; 1 turns stop into a no-op |
| i_mask | input | 1 | Mask for the maskable interrupt |
| x_mask | input | 1 | Mask for the non-maskable-style interrupt |
| irq_n | input | 1 | Maskable interrupt line, active low |
| xirq_n | input | 1 | Non-maskable-style interrupt line, active low |
| pin_rst_n | input | 1 | External reset pin, active low, used as a wake source |
| irq_pend | input | 1 | Latched pending edge-type maskable interrupt |
| settle_cycles | input | CNT_W | Oscillator settle count |
| rst_bypass_en | input | 1 | Lets a reset wake skip the settle count |
| core_clk_en | output | 1 | Core clock enable |
| osc_en | output | 1 | Oscillator enable |
| stop_active | output | 1 | Stopped or settling |
| stop_nop | output | 1 | One-cycle pulse: a stop request was turned into a no-op |
| wake_valid | output | 1 | One-cycle strobe marking the resume code |
| wake_code | output | 4 | One-hot resume code: bit0 next instruction, bit1 maskable service, bit2 non-maskable service, bit3 reset |

## Verification
The bench counts edges from the moment a wake line falls to the moment each enable rises.

- A design that dropped a synchronizer stage would come out early.
- A design that was off by one in the settle counter would come out early or late.
- A design that let the bypass apply to non-reset wakes would skip settling on an interrupt.

Two cases target the mask handling:

- A masked maskable interrupt is held for many cycles. A design that ignored `i_mask` would wake.
- A masked non-maskable-style wake must report "continue" rather than service.

Simultaneous sources check the priority order. A stop pulse injected mid-settle catches a design that re-enters the stopped state.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_SETTLE = 2'd2
    } stop_state_e;

    localparam int CAUSE_W    = 4;
    localparam int CAUSE_NEXT = 0;
    localparam int CAUSE_IRQ  = 1;
    localparam int CAUSE_XIRQ = 2;
    localparam int CAUSE_RST  = 3;

    typedef logic [CAUSE_W-1:0] cause_t;

endpackage

// File: rtl/stopctl_sync.sv
module stopctl_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/stopctl_wake_arb.sv
module stopctl_wake_arb
    import stopctl_pkg::*;
(
    input  logic   irq_n_s,
    input  logic   xirq_n_s,
    input  logic   prst_n_s,
    input  logic   pend_s,
    input  logic   i_mask,
    input  logic   x_mask,
    output logic   wake,
    output cause_t cause
);

    always_comb begin
        cause = '0;
        if (!prst_n_s) begin
            cause[CAUSE_RST] = 1'b1;
        end else if (!xirq_n_s) begin
            // masked line still wakes, but resumes in line
            cause[x_mask ? CAUSE_NEXT : CAUSE_XIRQ] = 1'b1;
        end else if (!i_mask && (!irq_n_s || pend_s)) begin
            cause[CAUSE_IRQ] = 1'b1;
        end
        wake = |cause;
    end

endmodule

// File: rtl/stopctl_top.sv
module stopctl_top
    import stopctl_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic             stop_dis,
    input  logic             i_mask,
    input  logic             x_mask,
    input  logic             irq_n,
    input  logic             xirq_n,
    input  logic             pin_rst_n,
    input  logic             irq_pend,
    input  logic [CNT_W-1:0] settle_cycles,
    input  logic             rst_bypass_en,
    output logic             core_clk_en,
    output logic             osc_en,
    output logic             stop_active,
    output logic             stop_nop,
    output logic             wake_valid,
    output logic [3:0]       wake_code
);

    localparam int           NSRC     = 4;
    localparam logic [NSRC-1:0] SYNC_IDLE = 4'b0111; // {pend, rst, xirq, irq}

    typedef struct packed {
        stop_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic             clk_en;
        logic             osc;
        logic             nop;
        logic             vld;
        cause_t           code;
        cause_t           held;
    } ctl_t;

    ctl_t r_q, r_d;

    logic [NSRC-1:0] raw_w, sync_w;
    logic            wake_w;
    cause_t          cause_w;

    assign raw_w = {irq_pend, pin_rst_n, xirq_n, irq_n};

    stopctl_sync #(
        .W      (NSRC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_IDLE)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_w),
        .dout (sync_w)
    );

    stopctl_wake_arb arb_i (
        .irq_n_s (sync_w[0]),
        .xirq_n_s(sync_w[1]),
        .prst_n_s(sync_w[2]),
        .pend_s  (sync_w[3]),
        .i_mask  (i_mask),
        .x_mask  (x_mask),
        .wake    (wake_w),
        .cause   (cause_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.nop  = 1'b0;
        r_d.vld  = 1'b0;
        r_d.code = '0;
        unique case (r_q.st)
            ST_RUN: begin
                if (stop_req) begin
                    if (stop_dis) begin
                        r_d.nop = 1'b1;
                    end else begin
                        r_d.st     = ST_STOP;
                        r_d.clk_en = 1'b0;
                        r_d.osc    = 1'b0;
                    end
                end
            end
            ST_STOP: begin
                if (wake_w) begin
                    r_d.osc  = 1'b1;
                    r_d.held = cause_w;
                    if (cause_w[CAUSE_RST] && rst_bypass_en) begin
                        r_d.st     = ST_RUN;
                        r_d.clk_en = 1'b1;
                        r_d.vld    = 1'b1;
                        r_d.code   = cause_w;
                    end else begin
                        r_d.st  = ST_SETTLE;
                        r_d.cnt = settle_cycles;
                    end
                end
            end
            ST_SETTLE: begin
                if (r_q.cnt == '0) begin
                    r_d.st     = ST_RUN;
                    r_d.clk_en = 1'b1;
                    r_d.vld    = 1'b1;
                    r_d.code   = r_q.held;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: begin
                r_d.st     = ST_RUN;
                r_d.clk_en = 1'b1;
                r_d.osc    = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_RUN;
            r_q.cnt    <= '0;
            r_q.clk_en <= 1'b1;
            r_q.osc    <= 1'b1;
            r_q.nop    <= 1'b0;
            r_q.vld    <= 1'b0;
            r_q.code   <= '0;
            r_q.held   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign core_clk_en = r_q.clk_en;
    assign osc_en      = r_q.osc;
    assign stop_active = (r_q.st != ST_RUN);
    assign stop_nop    = r_q.nop;
    assign wake_valid  = r_q.vld;
    assign wake_code   = r_q.code;

endmodule

// File: rtl/stopctl_chk.sv
module stopctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_req,
    input logic       stop_dis,
    input logic       core_clk_en,
    input logic       osc_en,
    input logic       stop_active,
    input logic       stop_nop,
    input logic       wake_valid,
    input logic [3:0] wake_code
);

    p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !stop_dis && !stop_active) |=> (stop_active && !core_clk_en && !osc_en));

    p_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && stop_dis && !stop_active) |=> (!stop_active && stop_nop && core_clk_en));

    p_clk_needs_osc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> osc_en);

    p_code_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> ($countones(wake_code) == 1));

    p_code_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_valid |-> (wake_code == 4'b0000));

    p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |=> !wake_valid);

    p_valid_on_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> wake_valid);

    p_no_reentry_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_active && !core_clk_en && osc_en) |=> osc_en);

endmodule

bind stopctl_top stopctl_chk chk_i (.*);

// File: tb/stopctl_tb.sv
module stopctl_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 5;
    localparam int NVEC       = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop_req = 1'b0, stop_dis = 1'b0;
    logic        i_mask = 1'b0, x_mask = 1'b0;
    logic        irq_n = 1'b1, xirq_n = 1'b1, pin_rst_n = 1'b1, irq_pend = 1'b0;
    logic [15:0] settle_cycles = 16'(SETTLE);
    logic        rst_bypass_en = 1'b0;
    logic        core_clk_en, osc_en, stop_active, stop_nop, wake_valid;
    logic [3:0]  wake_code;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stopctl_top dut_i (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_dis(stop_dis),
        .i_mask(i_mask), .x_mask(x_mask), .irq_n(irq_n), .xirq_n(xirq_n),
        .pin_rst_n(pin_rst_n), .irq_pend(irq_pend), .settle_cycles(settle_cycles),
        .rst_bypass_en(rst_bypass_en), .core_clk_en(core_clk_en), .osc_en(osc_en),
        .stop_active(stop_active), .stop_nop(stop_nop), .wake_valid(wake_valid),
        .wake_code(wake_code)
    );

    // im, xm, irq_n, xirq_n, prst_n, pend, bypass, expected code
    typedef struct packed {
        logic       im, xm, irq, xirq, prst, pend, byp;
        logic [3:0] code;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0010}, // R4 unmasked irq
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0010}, // R5 pending irq
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0100}, // R6 xirq X=0
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0001}, // R6 xirq X=1
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1000}, // R7 reset, settle
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b1000}, // R10 reset bypass
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1000}, // R8 all three
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0100}, // R8 xirq over irq
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0001}, // R8 masked xirq still wins
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0100}  // R10 bypass ignored
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic enter_stop(input logic im, input logic xm);
        @(negedge clk);
        i_mask = im; x_mask = xm; stop_dis = 1'b0; stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check(stop_active && !core_clk_en && !osc_en, "R2 enter stop",
              {29'd0, stop_active, core_clk_en, osc_en}, 4);
        repeat (2) @(negedge clk);
    endtask

    task automatic release_lines();
        irq_n = 1'b1; xirq_n = 1'b1; pin_rst_n = 1'b1; irq_pend = 1'b0;
        rst_bypass_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // drives wake lines at a falling edge, counts edges to each enable
    task automatic wake_measure(input vec_t v, input string req, input logic inject);
        int n = 0, osc_n = 0, exp_n;
        irq_n = v.irq; xirq_n = v.xirq; pin_rst_n = v.prst; irq_pend = v.pend;
        rst_bypass_en = v.byp;
        exp_n = (v.code == 4'b1000 && v.byp) ? 3 : SETTLE + 4;
        while (!core_clk_en && n < 100) begin
            @(negedge clk);
            n++;
            if (osc_en && osc_n == 0) osc_n = n;
            if (inject && n == 4) stop_req = 1'b1;
            else stop_req = 1'b0;
        end
        stop_req = 1'b0;
        check(osc_n == 3, {req, " / R9 osc restart"}, osc_n, 3);
        check(n == exp_n, {req, " / R9 R10 clock restart"}, n, exp_n);
        check(wake_valid && wake_code == v.code, {req, " code"}, wake_code, v.code);
        @(negedge clk);
        check(!wake_valid && wake_code == 4'b0 && core_clk_en && !stop_active,
              "R11 strobe one cycle / R12 stays running", wake_valid, 0);
        release_lines();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(core_clk_en && osc_en && !stop_active && !stop_nop && !wake_valid
              && wake_code == 4'b0, "R1 reset state", {27'd0, core_clk_en, osc_en,
              stop_active, stop_nop, wake_valid}, 24);

        for (int i = 0; i < NVEC; i++) begin
            enter_stop(VECS[i].im, VECS[i].xm);
            wake_measure(VECS[i], $sformatf("vector %0d", i), 1'b0);
        end

        // R3 stop disabled: no-op
        @(negedge clk);
        stop_dis = 1'b1; stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check(stop_nop && core_clk_en && osc_en && !stop_active, "R3 no-op pulse",
              {29'd0, stop_nop, core_clk_en, osc_en}, 7);
        @(negedge clk);
        check(!stop_nop && core_clk_en, "R3 no-op one cycle", stop_nop, 0);
        stop_dis = 1'b0;

        // R4 masked irq held low has no effect
        enter_stop(1'b1, 1'b0);
        irq_n = 1'b0;
        repeat (20) @(negedge clk);
        check(stop_active && !osc_en && !core_clk_en, "R4 masked irq ignored",
              {30'd0, osc_en, core_clk_en}, 0);
        wake_measure('{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0100},
                     "R4 R6 masked irq then xirq", 1'b0);

        // R12 stop request injected during settle
        enter_stop(1'b0, 1'b1);
        wake_measure('{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0001},
                     "R12 stop during settle", 1'b1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule